// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block sequences an external successive-approximation converter core over a group of up to four analog inputs. For each conversion it raises a one-cycle request that carries the channel number. It then waits for the core's done strobe and stores the returned sample in that channel's own result register. One control word holds the whole configuration: a run bit, a completion flag, an interrupt enable, a DMA-steer bit, a two-bit mode and a two-bit group size. Software writes the control word through a write strobe and reads it back on a separate port. A result read port selects one of the result registers.

Three modes exist. Single mode converts one chosen channel once. Multi mode converts channels 0 up to the group limit once. Scan mode repeats that group until software drops the run bit. The run bit can also be set by an external trigger pulse. At the end of every pass the block raises the completion flag. It then signals the event either as a level interrupt or as a one-cycle DMA request, depending on the steer bit.

Control word layout (bit positions are part of the behaviour): bit 0 run, bit 1 completion flag, bit 2 interrupt enable, bit 3 DMA steer, bits 5:4 mode, bits 7:6 group limit.

Top module: `adc_scan_seq`

## Requirements
- R1: A sample returned by the core is written only into the result register of the channel that was requested (result port select value = channel number). The other result registers keep their values, and all of them read 0 after reset.
- R2: Writing the control word with bit 0 = 1, or driving `trig_in` high for one cycle, sets the run bit and starts a pass.
- R3: In multi and scan modes every pass begins with channel 0. Each accepted done strobe moves the request to the next higher channel.
- R4: The group-limit field (bits 7:6) gives the highest channel of the group. A value k converts channels 0 through k, that is k+1 requests per pass.
- R5: Mode field (bits 5:4): 00 and 01 select single mode, 10 selects multi mode, 11 selects scan mode.
- R6: The completion flag (bit 1) is set when the last channel of a pass is accepted. A control write with bit 1 = 0 clears it. A write with bit 1 = 1 leaves it unchanged.
- R7: `irq` is high exactly while the flag, the interrupt enable (bit 2) and the inverse of the DMA steer bit (bit 3) are all 1.
- R8: With the DMA steer bit at 1, every pass end produces a `dma_req` pulse exactly one cycle wide.
- R9: In scan mode the run bit stays 1 at the end of a pass. The next request is channel 0 again, and passes repeat.
- R10: In multi mode the run bit is cleared by hardware after one pass. In single mode only the channel named by the group field is converted, once, and then the run bit is cleared.
- R11: Writing bit 0 = 0 stops the sequence. No request is issued after the following cycle, and a done strobe that arrives afterwards stores nothing. The next start begins at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| ctrl_rdata | output | 8 | Control word read data |
| trig_in | input | 1 | External start pulse |
| res_sel | input | 2 | Result register select |
| res_rdata | output | 10 | Selected result register |
| conv_req | output | 1 | One-cycle conversion request to the core |
| conv_ch | output | 2 | Channel of the current request |
| conv_done | input | 1 | Core finished, sample valid |
| conv_data | input | 10 | Sample from the core |
| irq | output | 1 | Completion interrupt level |
| dma_req | output | 1 | One-cycle completion pulse for DMA |

## Verification
The bench sweeps every group size in single and multi modes. For each size it checks that exactly the expected number of requests appear in ascending order, and that the untouched result registers hold their values. A design that misused the group field would convert one channel too many or too few, and one that wrote results to the wrong index would corrupt a neighbour. The bench runs scan mode for several passes, looking for a run bit that drops or a wrap that does not return to channel 0. It also clears the run bit between two conversions and lets the stale done strobe arrive: a sequencer that ignored the abort would keep requesting or would store that sample. Finally it checks that the steer bit routes the pass event either to a single-cycle DMA pulse or to the interrupt, never to both.

// File: rtl/adc_seq_pkg.sv
// Package: shared mode and state encodings for the ADC scan sequencer.
// Assumes a control word whose low six bits are fixed and whose group field
// sits directly above them.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_ONE_A = 2'b00,
        MODE_ONE_B = 2'b01,
        MODE_MULTI = 2'b10,
        MODE_SCAN  = 2'b11
    } seq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_WAIT = 2'b10
    } seq_state_e;

    localparam int BIT_RUN  = 0;
    localparam int BIT_FLAG = 1;
    localparam int BIT_IEN  = 2;
    localparam int BIT_DMA  = 3;
    localparam int BIT_MODE = 4;
    localparam int BIT_GRP  = 6;

endpackage

// File: rtl/adc_seq_ctrl.sv
// Module: control word of the sequencer. Holds the run bit, the completion
// flag, the interrupt enable, the DMA steer bit, the mode and the group limit.
// Assumes: a software write wins over the trigger, and the trigger wins over
// the hardware stop; a pass end sets the flag even if the same write clears it.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 2,
    localparam int CTRL_W = BIT_GRP + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              trig_in,
    input  logic              pass_end,
    input  logic              hw_stop,
    output logic              run,
    output logic              flag,
    output logic              ien,
    output logic              dma_sel,
    output seq_mode_e         mode,
    output logic [CH_W-1:0]   grp,
    output logic [CTRL_W-1:0] rdata
);

    // Run bit: software write, then external trigger, then hardware stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (reg_wr) begin
            run <= reg_wdata[BIT_RUN];
        end else if (trig_in) begin
            run <= 1'b1;
        end else if (hw_stop) begin
            run <= 1'b0;
        end
    end

    // Completion flag: set by a pass end, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (pass_end) begin
            flag <= 1'b1;
        end else if (reg_wr && !reg_wdata[BIT_FLAG]) begin
            flag <= 1'b0;
        end
    end

    // Plain configuration fields, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 1'b0;
            dma_sel <= 1'b0;
            mode    <= MODE_ONE_A;
            grp     <= '0;
        end else if (reg_wr) begin
            ien     <= reg_wdata[BIT_IEN];
            dma_sel <= reg_wdata[BIT_DMA];
            mode    <= seq_mode_e'(reg_wdata[BIT_MODE +: 2]);
            grp     <= reg_wdata[BIT_GRP +: CH_W];
        end
    end

    // Read-back view of the control word.
    always_comb begin
        rdata = {grp, mode, dma_sel, ien, flag, run};
    end

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_end |=> flag);

    p_scan_keeps_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && mode == MODE_SCAN && !reg_wr) |=> run);

    p_hw_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stop && !reg_wr && !trig_in) |=> !run);

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: channel walker. Issues one request per channel, waits for the core,
// advances through the group and reports pass ends.
// Assumes: the core answers each request with exactly one done strobe; a done
// strobe seen while the run bit is low is dropped.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  seq_mode_e       mode,
    input  logic [CH_W-1:0] grp,
    input  logic            conv_done,
    output logic            conv_req,
    output logic [CH_W-1:0] conv_ch,
    output logic            res_we,
    output logic            pass_end,
    output logic            hw_stop
);

    seq_state_e      state;
    logic [CH_W-1:0] ch;
    logic            is_scan;
    logic            is_single;
    logic            at_last;
    logic            accept;

    // Decode of mode and position within the group.
    always_comb begin
        is_scan   = (mode == MODE_SCAN);
        is_single = (mode == MODE_ONE_A) || (mode == MODE_ONE_B);
        at_last   = (ch == grp);
        accept    = (state == ST_WAIT) && conv_done && run;
        res_we    = accept;
        pass_end  = accept && at_last;
        hw_stop   = pass_end && !is_scan;
        conv_req  = (state == ST_REQ);
        conv_ch   = ch;
    end

    // State and channel pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ch    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run) begin
                        state <= ST_REQ;
                        ch    <= is_single ? grp : '0;
                    end
                end
                ST_REQ: begin
                    state <= run ? ST_WAIT : ST_IDLE;
                end
                ST_WAIT: begin
                    if (!run) begin
                        state <= ST_IDLE;
                    end else if (conv_done) begin
                        if (!at_last) begin
                            state <= ST_REQ;
                            ch    <= ch + 1'b1;
                        end else if (is_scan) begin
                            state <= ST_REQ;
                            ch    <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_stop_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !conv_req);

    p_first_ch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && run && !is_single) |=> (conv_req && conv_ch == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !at_last) |=> (conv_req && conv_ch == CH_W'($past(ch) + 1'b1)));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && is_scan) |=> (conv_req && conv_ch == '0));

endmodule

// File: rtl/adc_seq_results.sv
// Module: one result register per channel, written by channel index, read
// through a select mux.
// Assumes: the write index is always below NUM_CH.
module adc_seq_results #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 10,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] res_q [NUM_CH];

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_res
        // Capture a sample only for this channel's index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[gi] <= '0;
            end else if (we && wr_ch == CH_W'(gi)) begin
                res_q[gi] <= wr_data;
            end
        end

        p_only_own_ch_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && wr_ch == CH_W'(gi)) |=> $stable(res_q[gi]));
    end

    // Read mux.
    always_comb begin
        rd_data = res_q[rd_sel];
    end

endmodule

// File: rtl/adc_scan_seq.sv
// Module: top of the ADC scan sequencer. Ties the control word, the channel
// walker and the result bank together and forms the completion outputs.
// Assumes: the converter core is outside and speaks a request/done handshake.
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 10,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int CTRL_W = BIT_GRP + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              trig_in,
    input  logic [CH_W-1:0]   res_sel,
    output logic [DATA_W-1:0] res_rdata,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq,
    output logic              dma_req
);

    logic            run;
    logic            flag;
    logic            ien;
    logic            dma_sel;
    seq_mode_e       mode;
    logic [CH_W-1:0] grp;
    logic            res_we;
    logic            pass_end;
    logic            hw_stop;

    adc_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .trig_in  (trig_in),
        .pass_end (pass_end),
        .hw_stop  (hw_stop),
        .run      (run),
        .flag     (flag),
        .ien      (ien),
        .dma_sel  (dma_sel),
        .mode     (mode),
        .grp      (grp),
        .rdata    (ctrl_rdata)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mode     (mode),
        .grp      (grp),
        .conv_done(conv_done),
        .conv_req (conv_req),
        .conv_ch  (conv_ch),
        .res_we   (res_we),
        .pass_end (pass_end),
        .hw_stop  (hw_stop)
    );

    adc_seq_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (res_we),
        .wr_ch  (conv_ch),
        .wr_data(conv_data),
        .rd_sel (res_sel),
        .rd_data(res_rdata)
    );

    // Interrupt level: flag gated by enable and steered away by DMA select.
    always_comb begin
        irq = flag && ien && !dma_sel;
    end

    // DMA pulse: one cycle per pass end when steered to DMA.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req <= 1'b0;
        end else begin
            dma_req <= pass_end && dma_sel;
        end
    end

    p_irq_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && ien && !dma_sel && !reg_wr) |=> irq);

    p_dma_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

endmodule

// File: tb/adc_scan_seq_tb.sv
// Bench: sweeps group sizes and modes against a behavioural converter model.
module adc_scan_seq_tb;

    localparam int LAT = 3;
    localparam int LOG = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       trig_in = 1'b0;
    logic [1:0] res_sel = '0;
    logic [9:0] res_rdata;
    logic       conv_req;
    logic [1:0] conv_ch;
    logic       conv_done;
    logic [9:0] conv_data;
    logic       irq;
    logic       dma_req;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int         req_n = 0;
    int         done_n = 0;
    int         dma_n = 0;
    logic [1:0] req_log [LOG];
    logic [1:0] done_ch [LOG];
    logic [1:0] mdl_ch;
    int         mdl_cnt;
    logic [9:0] cur [4];

    always #4ns clk = ~clk;

    adc_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .ctrl_rdata(ctrl_rdata), .trig_in(trig_in), .res_sel(res_sel),
        .res_rdata(res_rdata), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_data(conv_data), .irq(irq), .dma_req(dma_req)
    );

    function automatic logic [9:0] fdat(int idx, int ch);
        return 10'((idx * 53 + ch * 7 + 11) % 1024);
    endfunction

    // Converter model: fixed latency, logs requests and returned samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            conv_done <= 1'b0;
            conv_data <= '0;
            mdl_cnt   <= 0;
            mdl_ch    <= '0;
        end else begin
            conv_done <= 1'b0;
            if (mdl_cnt > 0) begin
                mdl_cnt <= mdl_cnt - 1;
                if (mdl_cnt == 1) begin
                    conv_done <= 1'b1;
                    conv_data <= fdat(done_n, int'(mdl_ch));
                    done_ch[done_n % LOG] <= mdl_ch;
                    done_n <= done_n + 1;
                end
            end
            if (conv_req) begin
                mdl_ch <= conv_ch;
                mdl_cnt <= LAT;
                req_log[req_n % LOG] <= conv_ch;
                req_n <= req_n + 1;
            end
        end
    end

    always @(negedge clk) if (rst_n && dma_req) dma_n++;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] cw(bit st, bit fl, bit ie, bit dm, logic [1:0] md, logic [1:0] gs);
        return {gs, md, dm, ie, fl, st};
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            if (!ctrl_rdata[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic apply(input int from, input int upto);
        for (int i = from; i < upto; i++) cur[done_ch[i % LOG]] = fdat(i, int'(done_ch[i % LOG]));
    endtask

    task automatic chk_results(input string rq);
        for (int c = 0; c < 4; c++) begin
            res_sel = 2'(c);
            #1;
            chk(res_rdata == cur[c], rq, int'(res_rdata), int'(cur[c]));
        end
    endtask

    task automatic rebase();
        for (int c = 0; c < 4; c++) begin
            res_sel = 2'(c);
            #1;
            cur[c] = res_rdata;
        end
    endtask

    function automatic int count_pass(int from, int last);
        int n = 0;
        for (int i = from; i < done_n; i++) if (int'(done_ch[i % LOG]) == last) n++;
        return n;
    endfunction

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int rb, db, dn, rq, da, ok;
        for (int c = 0; c < 4; c++) cur[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R6, R7)
        chk(ctrl_rdata == 8'h00, "R6 reset control word", int'(ctrl_rdata), 0);
        chk(!irq && !dma_req && !conv_req, "R7 reset outputs", int'({irq, dma_req, conv_req}), 0);
        chk_results("R1 reset results");

        // Multi mode sweep over all group sizes (R1, R3, R4, R6, R7, R10)
        for (int k = 0; k < 4; k++) begin
            wr(cw(0, 0, 1, 0, 2'b10, 2'(k)));
            rb = req_n; db = done_n;
            wr(cw(1, 1, 1, 0, 2'b10, 2'(k)));
            wait_idle();
            chk(req_n - rb == k + 1, "R4 request count", req_n - rb, k + 1);
            ok = 1;
            for (int i = 0; i < req_n - rb; i++) if (int'(req_log[(rb + i) % LOG]) != i) ok = 0;
            chk(ok == 1, "R3 ascending from 0", ok, 1);
            chk(ctrl_rdata[0] == 1'b0, "R10 multi run cleared", int'(ctrl_rdata[0]), 0);
            chk(ctrl_rdata[1] == 1'b1, "R6 flag set", int'(ctrl_rdata[1]), 1);
            chk(irq == 1'b1, "R7 irq raised", int'(irq), 1);
            apply(db, done_n);
            chk_results("R1 multi results");
            wr(cw(0, 1, 1, 0, 2'b10, 2'(k)));
            chk(ctrl_rdata[1] == 1'b1, "R6 write 1 keeps flag", int'(ctrl_rdata[1]), 1);
            wr(cw(0, 0, 1, 0, 2'b10, 2'(k)));
            chk(ctrl_rdata[1] == 1'b0, "R6 write 0 clears flag", int'(ctrl_rdata[1]), 0);
            chk(irq == 1'b0, "R7 irq follows flag", int'(irq), 0);
        end

        // Single mode: both encodings, every channel (R1, R5, R10)
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 4; k++) begin
                rb = req_n; db = done_n;
                wr(cw(1, 0, 0, 0, 2'(m), 2'(k)));
                wait_idle();
                repeat (2) @(negedge clk);
                chk(req_n - rb == 1, "R10 single one request", req_n - rb, 1);
                chk(int'(req_log[rb % LOG]) == k, "R5 single channel", int'(req_log[rb % LOG]), k);
                chk(ctrl_rdata[1] == 1'b1, "R6 single flag", int'(ctrl_rdata[1]), 1);
                apply(db, done_n);
                chk_results("R1 single results");
            end
        end

        // External trigger (R2)
        wr(cw(0, 0, 0, 0, 2'b10, 2'd1));
        rb = req_n; db = done_n;
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
        chk(ctrl_rdata[0] == 1'b1, "R2 trigger sets run", int'(ctrl_rdata[0]), 1);
        wait_idle();
        chk(req_n - rb == 2, "R2 trigger pass", req_n - rb, 2);
        apply(db, done_n);
        chk_results("R1 trigger results");

        // DMA steer (R7, R8)
        wr(cw(0, 0, 1, 1, 2'b10, 2'd3));
        dn = dma_n; db = done_n;
        wr(cw(1, 1, 1, 1, 2'b10, 2'd3));
        wait_idle();
        @(negedge clk);
        chk(dma_n - dn == 1, "R8 one dma cycle per pass", dma_n - dn, 1);
        chk(ctrl_rdata[1] == 1'b1, "R6 flag under dma", int'(ctrl_rdata[1]), 1);
        chk(irq == 1'b0, "R7 irq blocked by dma", int'(irq), 0);
        apply(db, done_n);

        // Scan mode: repeat passes, wrap to 0, flag re-set (R3, R9, R11)
        wr(cw(0, 0, 1, 0, 2'b11, 2'd2));
        rb = req_n; db = done_n;
        wr(cw(1, 1, 1, 0, 2'b11, 2'd2));
        for (int i = 0; i < 300 && count_pass(db, 2) < 3; i++) @(negedge clk);
        chk(count_pass(db, 2) >= 3, "R9 scan repeats", count_pass(db, 2), 3);
        chk(ctrl_rdata[0] == 1'b1, "R9 run stays set", int'(ctrl_rdata[0]), 1);
        ok = 1;
        for (int i = 0; i < req_n - rb; i++) if (int'(req_log[(rb + i) % LOG]) != i % 3) ok = 0;
        chk(ok == 1, "R9 wrap order", ok, 1);
        wr(cw(1, 0, 1, 0, 2'b11, 2'd2));
        da = count_pass(db, 2);
        for (int i = 0; i < 300 && count_pass(db, 2) < da + 2; i++) @(negedge clk);
        @(negedge clk);
        chk(ctrl_rdata[1] == 1'b1, "R6 flag set again in scan", int'(ctrl_rdata[1]), 1);
        wr(cw(0, 1, 1, 0, 2'b11, 2'd2));
        @(negedge clk);
        rq = req_n;
        repeat (20) @(negedge clk);
        chk(req_n == rq, "R11 scan stops", req_n, rq);
        chk(ctrl_rdata[0] == 1'b0, "R11 run low", int'(ctrl_rdata[0]), 0);
        rebase();

        // Abort mid-pass, stale done ignored, restart at 0 (R11)
        wr(cw(0, 0, 0, 0, 2'b10, 2'd3));
        rb = req_n; db = done_n;
        wr(cw(1, 1, 0, 0, 2'b10, 2'd3));
        for (int i = 0; i < 100 && req_n < rb + 2; i++) @(negedge clk);
        da = done_n;
        wr(cw(0, 1, 0, 0, 2'b10, 2'd3));
        repeat (20) @(negedge clk);
        chk(req_n == rb + 2, "R11 no request after abort", req_n, rb + 2);
        chk(ctrl_rdata[1] == 1'b0, "R11 no flag on abort", int'(ctrl_rdata[1]), 0);
        apply(db, da);
        chk_results("R11 stale sample dropped");
        rb = req_n; db = done_n;
        wr(cw(1, 1, 0, 0, 2'b10, 2'd3));
        wait_idle();
        chk(int'(req_log[rb % LOG]) == 0, "R11 restart at channel 0", int'(req_log[rb % LOG]), 0);
        chk(req_n - rb == 4, "R11 full pass after restart", req_n - rb, 4);
        apply(db, done_n);
        chk_results("R1 results after restart");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule